// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block decides where an access below 1 MiB should go. It keeps a few byte-wide chipset configuration registers that software writes one byte at a time. It splits the range from 0xA0000 up to 0x100000 into fourteen segments, and each segment carries a 2-bit attribute. For every lookup the block reports one of three outcomes:

- the access goes to DRAM;
- the segment behaves as read-only DRAM;
- the access is forwarded to the legacy bus.

A window of system-management memory can be laid over the segments. When the window is enabled it sends the accesses it covers to DRAM, whatever the segment attributes say. One of its enable bits counts only while the system-management mode input is high.

A lookup presents an address and a read/write flag. The routing decision appears one clock later, with a flag that marks writes the block has dropped. Configuration writes and changes of the mode input are registered. A lookup therefore always sees the configuration as it stood at the start of its own cycle.

Top module: `legacy_region_decoder`

## Requirements
- R1: The segments are [0xA0000,0xC0000), then twelve 16 KiB segments from 0xC0000 to 0xF0000, then [0xF0000,0x100000). Segment i covers the i-th of these ranges, counting from 0.
- R2: The attribute of segment i is bits [1:0] of a nibble in configuration byte 0x61 + (i>>1). Even i uses bits [1:0] of that byte and odd i uses bits [5:4]. Bits [3:2] and [7:6] have no effect.
- R3: Route codes are 0 = not decoded, 1 = DRAM, 2 = legacy bus, 3 = write dropped. Attribute 3 gives route 1 for reads and writes. Attribute 2 gives route 1 for reads. Attributes 0 and 1 give route 2.
- R4: A write to a segment with attribute 2 gives route 3 with the write-blocked flag high. The flag is high only in that response cycle.
- R5: An address below 0xA0000 or at or above 0x100000 gives route 0 with the write-blocked flag low.
- R6: After reset all attribute bytes are 0. The 32-bit window control at bytes 0x6C..0x6F (0x6C least significant) holds 0x0000000A.
- R7: The window is enabled when control bit 26 is 1, or when bit 31 is 1 while the registered mode input is 1.
- R8: The window base is control[15:0] << 16 and its size is (control[23:20] + 1) × 64 KiB. An enabled window gives route 1 inside [base, base+size), for reads and writes, without the write-blocked flag.
- R9: The window applies only when base ≥ 0xA0000 and base+size ≤ 0x100000. Otherwise the segment attributes decide.
- R10: The response valid is high exactly one cycle after a lookup request. When it is low, the route is 0 and the flag is low.
- R11: A configuration write or a mode-input change affects lookups from the next cycle on. A lookup in the same cycle uses the old values.
- R12: Writes to offsets outside 0x61..0x67 and 0x6C..0x6F change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| smm_mode | input | 1 | System-management mode indication |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup physical address |
| lk_write | input | 1 | Lookup is a write |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_route | output | 2 | Route code (R3) |
| rsp_wblock | output | 1 | Write dropped because the segment is read-only |

## Verification
A configuration write, or a toggle of the mode input, can land in the same cycle as a lookup that depends on it. The bench provokes this in directed steps that do two things in one cycle:

- rewrite the attribute of segment 0 while looking up 0xA0000;
- toggle the mode input while looking up inside the window, with only bit 31 set.

It expects the old routing in that response and the new routing one cycle later. Random traffic then mixes writes to control bytes, mode toggles and lookups in the same cycles, all checked against a bench model that applies every update only after the clock edge.

// File: rtl/lrd_pkg.sv
`timescale 1ns/1ps
package lrd_pkg;

    localparam int SEG_COUNT = 14;
    localparam int FINE_SEGS = 12;

    localparam logic [31:0] LEGACY_LO  = 32'h000A_0000;
    localparam logic [31:0] LEGACY_HI  = 32'h0010_0000;
    localparam logic [31:0] FINE_LO    = 32'h000C_0000;
    localparam logic [31:0] FINE_STEP  = 32'h0000_4000;
    localparam logic [31:0] TOP_SEG_LO = 32'h000F_0000;

    localparam logic [1:0] ATTR_RW = 2'd3;
    localparam logic [1:0] ATTR_RO = 2'd2;

    typedef enum logic [1:0] {
        ROUTE_PASS   = 2'd0,
        ROUTE_DRAM   = 2'd1,
        ROUTE_LEGACY = 2'd2,
        ROUTE_DROP   = 2'd3
    } route_e;

    typedef struct packed {
        logic   valid;
        route_e route;
        logic   wblock;
    } rsp_t;

    // Lower bound of segment idx; idx == SEG_COUNT returns the end of the last segment.
    function automatic logic [31:0] seg_lo(input int idx);
        if (idx <= 0)
            return LEGACY_LO;
        if (idx <= FINE_SEGS)
            return FINE_LO + FINE_STEP * 32'(idx - 1);
        if (idx == FINE_SEGS + 1)
            return TOP_SEG_LO;
        return LEGACY_HI;
    endfunction

endpackage

// File: rtl/lrd_cfg_regs.sv
`timescale 1ns/1ps
module lrd_cfg_regs #(
    parameter int          NUM_SEG     = 14,
    parameter logic [7:0]  ATTR_BASE   = 8'h61,
    parameter logic [7:0]  SMRAM_BASE  = 8'h6C,
    parameter logic [31:0] SMRAM_RESET = 32'h0000_000A,
    localparam int         ATTR_BYTES  = (NUM_SEG + 1) / 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [7:0]              cfg_off,
    input  logic [7:0]              cfg_wdata,
    input  logic                    smm_in,
    output logic [ATTR_BYTES*8-1:0] attr_bytes,
    output logic [31:0]             smram_ctl,
    output logic                    smm_q
);

    localparam int SMRAM_BYTES = 4;

    typedef struct packed {
        logic [ATTR_BYTES-1:0][7:0] attr;
        logic [31:0]                smram;
        logic                       smm;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic attr_sel;
    logic smram_sel;

    always_comb begin
        attr_sel  = cfg_we && (cfg_off >= ATTR_BASE) &&
                    (cfg_off < ATTR_BASE + 8'(ATTR_BYTES));
        smram_sel = cfg_we && (cfg_off >= SMRAM_BASE) &&
                    (cfg_off < SMRAM_BASE + 8'(SMRAM_BYTES));
    end

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.smm = smm_in;
        if (cfg_we) begin
            for (int b = 0; b < ATTR_BYTES; b++) begin
                if (cfg_off == ATTR_BASE + 8'(b))
                    cfg_d.attr[b] = cfg_wdata;
            end
            for (int k = 0; k < SMRAM_BYTES; k++) begin
                if (cfg_off == SMRAM_BASE + 8'(k))
                    cfg_d.smram[8*k +: 8] = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.attr  <= '0;
            cfg_q.smram <= SMRAM_RESET;
            cfg_q.smm   <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign attr_bytes = cfg_q.attr;
    assign smram_ctl  = cfg_q.smram;
    assign smm_q      = cfg_q.smm;

    // Byte 0 of the attribute bank takes the written data on the next edge.
    assert_attr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_off == ATTR_BASE) |=> (cfg_q.attr[0] == $past(cfg_wdata)));

    // The highest control byte sits at the top of the little-endian word.
    assert_smram_le_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_off == SMRAM_BASE + 8'd3) |=> (cfg_q.smram[31:24] == $past(cfg_wdata)));

    assert_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!attr_sel && !smram_sel) |=> ($stable(cfg_q.attr) && $stable(cfg_q.smram)));

    assert_mode_reg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cfg_q.smm == $past(smm_in)));

endmodule

// File: rtl/lrd_seg_map.sv
`timescale 1ns/1ps
module lrd_seg_map
    import lrd_pkg::*;
#(
    parameter int  ADDR_W     = 32,
    parameter int  NUM_SEG    = SEG_COUNT,
    localparam int ATTR_BYTES = (NUM_SEG + 1) / 2,
    localparam int CW         = (ADDR_W > 32) ? ADDR_W + 1 : 33
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [ATTR_BYTES*8-1:0] attr_bytes,
    output logic [NUM_SEG-1:0]      seg_hit,
    output logic [1:0]              attr
);

    logic [CW-1:0]              a_ext;
    logic [NUM_SEG-1:0][1:0]    field;
    logic                       attr_bytes_unused;

    assign a_ext             = CW'(addr);
    assign attr_bytes_unused = ^attr_bytes;

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        localparam logic [CW-1:0] SEG_LO = CW'(seg_lo(i));
        localparam logic [CW-1:0] SEG_HI = CW'(seg_lo(i + 1));
        localparam int            NIB    = (i >> 1) * 8 + (i & 1) * 4;

        assign seg_hit[i] = (a_ext >= SEG_LO) && (a_ext < SEG_HI);
        assign field[i]   = attr_bytes[NIB +: 2];
    end

    always_comb begin
        attr = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (seg_hit[i])
                attr = attr | field[i];
        end
    end

endmodule

// File: rtl/lrd_smram_win.sv
`timescale 1ns/1ps
module lrd_smram_win
    import lrd_pkg::*;
#(
    parameter int  ADDR_W = 32,
    localparam int CW     = (ADDR_W > 32) ? ADDR_W + 1 : 33
) (
    input  logic [31:0]       smram_ctl,
    input  logic              smm,
    input  logic [ADDR_W-1:0] addr,
    output logic              applied,
    output logic              hit
);

    logic          active;
    logic          fits;
    logic [CW-1:0] base;
    logic [CW-1:0] size;
    logic [CW-1:0] lim;
    logic [CW-1:0] a_ext;
    logic          ctl_unused;

    assign ctl_unused = ^{smram_ctl[30:27], smram_ctl[25:24], smram_ctl[19:16]};

    always_comb begin
        a_ext   = CW'(addr);
        active  = smram_ctl[26] | (smm & smram_ctl[31]);
        base    = CW'({smram_ctl[15:0], 16'h0000});
        size    = CW'({1'b0, smram_ctl[23:20]} + 5'd1) << 16;
        lim     = base + size;
        fits    = (base >= CW'(LEGACY_LO)) && (lim <= CW'(LEGACY_HI));
        applied = active && fits;
        hit     = applied && (a_ext >= base) && (a_ext < lim);
    end

endmodule

// File: rtl/legacy_region_decoder.sv
`timescale 1ns/1ps
module legacy_region_decoder
    import lrd_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          NUM_SEG     = SEG_COUNT,
    parameter logic [7:0]  ATTR_BASE   = 8'h61,
    parameter logic [7:0]  SMRAM_BASE  = 8'h6C,
    parameter logic [31:0] SMRAM_RESET = 32'h0000_000A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_off,
    input  logic [7:0]        cfg_wdata,
    input  logic              smm_mode,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_write,
    output logic              rsp_valid,
    output logic [1:0]        rsp_route,
    output logic              rsp_wblock
);

    localparam int ATTR_BYTES = (NUM_SEG + 1) / 2;

    logic [ATTR_BYTES*8-1:0] attr_bytes;
    logic [31:0]             smram_ctl;
    logic                    smm_q;
    logic [NUM_SEG-1:0]      seg_hit;
    logic [1:0]              seg_attr;
    logic                    win_applied;
    logic                    win_hit;

    rsp_t rsp_d, rsp_q;

    lrd_cfg_regs #(
        .NUM_SEG     (NUM_SEG),
        .ATTR_BASE   (ATTR_BASE),
        .SMRAM_BASE  (SMRAM_BASE),
        .SMRAM_RESET (SMRAM_RESET)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_off    (cfg_off),
        .cfg_wdata  (cfg_wdata),
        .smm_in     (smm_mode),
        .attr_bytes (attr_bytes),
        .smram_ctl  (smram_ctl),
        .smm_q      (smm_q)
    );

    lrd_seg_map #(
        .ADDR_W  (ADDR_W),
        .NUM_SEG (NUM_SEG)
    ) u_seg (
        .addr       (lk_addr),
        .attr_bytes (attr_bytes),
        .seg_hit    (seg_hit),
        .attr       (seg_attr)
    );

    lrd_smram_win #(
        .ADDR_W (ADDR_W)
    ) u_win (
        .smram_ctl (smram_ctl),
        .smm       (smm_q),
        .addr      (lk_addr),
        .applied   (win_applied),
        .hit       (win_hit)
    );

    always_comb begin
        rsp_d        = '0;
        rsp_d.route  = ROUTE_PASS;
        if (lk_valid) begin
            rsp_d.valid = 1'b1;
            if (seg_hit == '0) begin
                rsp_d.route = ROUTE_PASS;
            end else if (win_hit) begin
                rsp_d.route = ROUTE_DRAM;
            end else begin
                case (seg_attr)
                    ATTR_RW: rsp_d.route = ROUTE_DRAM;
                    ATTR_RO: begin
                        if (lk_write) begin
                            rsp_d.route  = ROUTE_DROP;
                            rsp_d.wblock = 1'b1;
                        end else begin
                            rsp_d.route = ROUTE_DRAM;
                        end
                    end
                    default: rsp_d.route = ROUTE_LEGACY;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '{valid: 1'b0, route: ROUTE_PASS, wblock: 1'b0};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_route  = rsp_q.route;
    assign rsp_wblock = rsp_q.wblock;

    assert_seg_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot0(seg_hit));

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && rsp_route == ROUTE_PASS && !rsp_wblock));

    assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wblock |-> (rsp_valid && rsp_route == ROUTE_DROP && $past(lk_write)));

    assert_outside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (lk_addr < ADDR_W'(LEGACY_LO) || lk_addr >= ADDR_W'(LEGACY_HI)))
        |=> (rsp_route == ROUTE_PASS && !rsp_wblock));

    assert_win_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (smram_ctl[26] || (smm_q && smram_ctl[31])));

    assert_win_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && win_hit) |=> (rsp_route == ROUTE_DRAM && !rsp_wblock));

    assert_win_fit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (win_applied && seg_hit != '0));

endmodule

// File: tb/tb_legacy_region_decoder.sv
`timescale 1ns/1ps
module tb_legacy_region_decoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [7:0]  cfg_off;
    logic [7:0]  cfg_wdata;
    logic        smm_mode;
    logic        lk_valid;
    logic [31:0] lk_addr;
    logic        lk_write;
    logic        rsp_valid;
    logic [1:0]  rsp_route;
    logic        rsp_wblock;

    always #5 clk = ~clk;

    legacy_region_decoder dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_off    (cfg_off),
        .cfg_wdata  (cfg_wdata),
        .smm_mode   (smm_mode),
        .lk_valid   (lk_valid),
        .lk_addr    (lk_addr),
        .lk_write   (lk_write),
        .rsp_valid  (rsp_valid),
        .rsp_route  (rsp_route),
        .rsp_wblock (rsp_wblock)
    );

    int errors = 0;
    int checks = 0;
    byte unsigned attr_m [7];
    byte unsigned ctl_m [4];
    bit  smm_m;
    bit  smm_cur;

    // Returns {wblock, route}: route 0 none, 1 DRAM, 2 legacy, 3 dropped.
    function automatic logic [2:0] expect_rsp(input longint addr, input bit wr);
        longint ctl, base, size, seg;
        int     a;
        bit     act;
        if (addr < 64'hA0000 || addr >= 64'h100000) return 3'b000;
        ctl  = {ctl_m[3], ctl_m[2], ctl_m[1], ctl_m[0]};
        act  = ctl[26] || (smm_m && ctl[31]);
        base = (ctl & 64'hFFFF) << 16;
        size = (((ctl >> 20) & 64'hF) + 1) << 16;
        if (act && base >= 64'hA0000 && base + size <= 64'h100000 &&
            addr >= base && addr < base + size) return 3'b001;
        if (addr < 64'hC0000)      seg = 0;
        else if (addr < 64'hF0000) seg = 1 + (addr - 64'hC0000) / 64'h4000;
        else                       seg = 13;
        a = (int'(attr_m[seg / 2]) >> ((seg % 2) * 4)) & 3;
        if (a == 3) return 3'b001;
        if (a == 2) return wr ? 3'b111 : 3'b001;
        return 3'b010;
    endfunction

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got valid/wblock/route=%b expected %b", tag, got, exp);
        end
    endtask

    task automatic cyc(input bit we, input int off, input int wd, input bit lv,
                       input longint addr, input bit wr, input string tag);
        logic [3:0] exp;
        cfg_we    = we;
        cfg_off   = 8'(off);
        cfg_wdata = 8'(wd);
        smm_mode  = smm_cur;
        lk_valid  = lv;
        lk_addr   = 32'(addr);
        lk_write  = wr;
        exp = lv ? {1'b1, expect_rsp(addr, wr)} : 4'b0000;
        @(posedge clk);
        #1;
        if (we) begin
            if (off >= 'h61 && off <= 'h67) attr_m[off - 'h61] = 8'(wd);
            if (off >= 'h6C && off <= 'h6F) ctl_m[off - 'h6C] = 8'(wd);
        end
        smm_m = smm_cur;
        @(negedge clk);
        check(tag, {rsp_valid, rsp_wblock, rsp_route}, exp);
    endtask

    task automatic wr_cfg(input int off, input int wd, input string tag);
        cyc(1'b1, off, wd, 1'b0, 0, 1'b0, tag);
    endtask

    task automatic look(input longint addr, input bit wr, input string tag);
        cyc(1'b0, 0, 0, 1'b1, addr, wr, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4021));
        foreach (attr_m[i]) attr_m[i] = 8'h00;
        ctl_m[0] = 8'h0A; ctl_m[1] = 8'h00; ctl_m[2] = 8'h00; ctl_m[3] = 8'h00;
        smm_m = 1'b0; smm_cur = 1'b0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_off = '0; cfg_wdata = '0;
        smm_mode = 1'b0; lk_valid = 1'b0; lk_addr = '0; lk_write = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset outputs", {rsp_valid, rsp_wblock, rsp_route}, 4'b0000);

        // Reset attributes and outside addresses
        look(64'hA0000, 1'b0, "R6 reset attr legacy");
        look(64'h9FFFF, 1'b0, "R5 below range");
        look(64'h100000, 1'b1, "R5 above range");
        look(64'hFFFFF, 1'b0, "R1 last byte");
        cyc(1'b0, 0, 0, 1'b0, 0, 1'b0, "R10 idle");

        // Same-cycle write and lookup
        cyc(1'b1, 'h61, 'h32, 1'b1, 64'hA0000, 1'b1, "R11 same-cycle old attr");
        look(64'hA0000, 1'b1, "R4 write to read-only");
        cyc(1'b0, 0, 0, 1'b0, 0, 1'b0, "R4 flag one cycle");
        look(64'hA0000, 1'b0, "R3 read-only read");
        look(64'hC0000, 1'b1, "R2 odd segment high nibble");
        look(64'hBFFFF, 1'b1, "R1 seg0 last byte");

        wr_cfg('h67, 'h13, "R2 write 0x67");
        look(64'hEFFFF, 1'b1, "R1 seg12 top");
        look(64'hF0000, 1'b1, "R1 seg13 start");
        look(64'hEBFFF, 1'b0, "R1 seg11 top");
        wr_cfg('h64, 'hC2, "R2 write 0x64");
        look(64'hD4000, 1'b1, "R2 seg6 read-only");
        look(64'hD8000, 1'b0, "R2 upper nibble bits ignored");

        // Offsets outside the register set
        wr_cfg('h60, 'hFF, "R12 write 0x60");
        wr_cfg('h68, 'hFF, "R12 write 0x68");
        wr_cfg('h6B, 'hFF, "R12 write 0x6B");
        wr_cfg('h70, 'hFF, "R12 write 0x70");
        look(64'hF0000, 1'b0, "R12 attr unchanged");
        look(64'hA8000, 1'b1, "R12 window unchanged");

        // Window 0xB0000..0xCFFFF enabled by bit 26
        wr_cfg('h6C, 'h0B, "R8 base");
        wr_cfg('h6D, 'h00, "R8 base hi");
        wr_cfg('h6E, 'h10, "R8 size");
        wr_cfg('h6F, 'h04, "R8 enable");
        look(64'hB0000, 1'b1, "R8 override read-only");
        look(64'hAFFFF, 1'b1, "R8 below window");
        look(64'hCFFFF, 1'b1, "R8 window last byte");
        look(64'hD0000, 1'b1, "R8 above window");

        wr_cfg('h6C, 'h0F, "R9 base 0xF0000");
        look(64'hF0000, 1'b0, "R9 window overflows top");
        wr_cfg('h6E, 'h00, "R9 size 64K");
        look(64'hF0000, 1'b1, "R9 window fits");
        wr_cfg('h6C, 'h09, "R9 base below range");
        look(64'hA0000, 1'b1, "R9 low window ignored");

        // Bit 31 gated by mode
        wr_cfg('h6F, 'h80, "R7 bit31 only");
        wr_cfg('h6C, 'h0A, "R7 base");
        look(64'hA0000, 1'b1, "R7 mode low");
        smm_cur = 1'b1;
        look(64'hA0000, 1'b1, "R11 mode rise same cycle");
        look(64'hA0000, 1'b1, "R7 mode high");
        smm_cur = 1'b0;
        look(64'hA0000, 1'b1, "R11 mode fall same cycle");
        look(64'hA0000, 1'b1, "R7 mode low again");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            bit     we, lv, wr;
            int     off, wd;
            longint addr;
            we  = ($urandom % 4) == 0;
            off = 'h60 + int'($urandom % 17);
            wd  = int'($urandom % 256);
            if (off == 'h6C) wd = 'h08 + int'($urandom % 9);
            if (off == 'h6D) wd = (($urandom % 8) == 0) ? wd : 0;
            if (($urandom % 8) == 0) smm_cur = ~smm_cur;
            lv   = ($urandom % 4) != 0;
            wr   = $urandom % 2;
            addr = 64'h98000 + longint'($urandom % 32'h70000);
            cyc(we, off, wd, lv, addr, wr, "R3 R8 R11 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule